// File: doc/BRIEF.md
# Dual Transfer-Machine Fault-Injection Sequencer

This block drives two identical three-state transfer machines at the same time and checks them against each other's expected result. One machine has no way back from an unused state encoding. The other falls back to idle from any such encoding. Once per test period the sequencer places a 16-bit test word on the shared data input. It commands a capture (read) and then a replay (write). It then compares what each machine drives back against the word.

Each machine has its own 8-bit mismatch tally. Both tallies are packed into one 16-bit word for a display driver. One switch forces the state-corruption code onto both machines' injection pins. A second switch holds both machines in reset, clears the tallies and the word, and stops mismatches from being counted. A machine that locks up keeps failing on every later period until the reset switch is used, so the two tallies show the benefit of the recovery logic.

The period length is a parameter. Its default, 20,000,000 cycles, gives one test per second from a 20 MHz clock.

Top module: `fsm_fault_sequencer`

## Requirements
- R1: When `sw_inject` is 1, `tm_inject` is 2'b11. When it is 0, `tm_inject` is 2'b00. No other code ever appears.
- R2: While `sw_reset` is 1, `tm_rst` is 1. From the cycle after `sw_reset` is sampled high, both tallies (`display_word`) and `tm_word` read zero and stay zero for as long as the switch is held.
- R3: `tm_word` is the same 16-bit value for both machines. It starts at 0 and goes up by one after every comparison made while the reset switch is low.
- R4: Within each period, counting phases 0 to PERIOD_CYCLES-1 from reset release:
  - `tm_start` is high only at phase 0 (with `tm_rw`=0, read) and at phase 3 (with `tm_rw`=1, write).
  - `tm_start` is low at every other phase.
  - The next period begins PERIOD_CYCLES cycles later.
- R5: Both outputs are compared at phase 6. The result shows on `plain_status` and `guard_status` from phase 7. The codes are 2'b00 ok (match), 2'b01 faulted (mismatch, reset switch low) and 2'b10 in-reset (mismatch, reset switch high).
- R6: A machine's tally goes up by one on a mismatch at a comparison only when `sw_reset` is low. A mismatch under reset gives the in-reset code and leaves the tally at zero. A machine that stays locked keeps adding one per period.
- R7: A tally that has reached 8'hFF stays at 8'hFF on further mismatches.
- R8: `display_word[15:8]` carries the protected machine's tally. `display_word[7:0]` carries the unprotected machine's tally.
- R9: After `rst_n` is released, the word and both tallies are zero and both status codes read ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_inject | input | 1 | Fault-injection switch (synchronous to clk) |
| sw_reset | input | 1 | Machine reset / tally clear switch (synchronous to clk) |
| plain_dout | input | 16 | Output word of the unprotected machine |
| guard_dout | input | 16 | Output word of the protected machine |
| tm_rst | output | 1 | Reset to both machines |
| tm_start | output | 1 | Start pulse to both machines |
| tm_rw | output | 1 | 0 = read, 1 = write, to both machines |
| tm_inject | output | 2 | Corruption code to both machines |
| tm_word | output | 16 | Test word to both machines |
| display_word | output | 16 | Packed tallies {protected, unprotected} |
| plain_status | output | 2 | Last comparison result, unprotected machine |
| guard_status | output | 2 | Last comparison result, protected machine |

## Verification
The command outputs, the reset line and the injection code follow the phase counter and the switches in the same cycle. The bench samples them at the negative edge of the phase it expects.

The comparison is registered at phase 6, so status, tallies and the incremented word are due one edge later. Every result check is made at phase 7. The clearing effect of the reset switch is due one edge after it is raised and is checked at the following negative edge.

The bench keeps a global cycle count from reset release and moves to an exact phase before each check. Its behavioural machines (one locks up, one recovers) add one edge for read entry, one for capture, one for write entry and one for output. The replayed word is therefore stable by phase 5, ahead of the phase-6 comparison.

// File: rtl/fsm_fault_sequencer.sv
module fsm_fault_sequencer #(
  parameter int unsigned PERIOD_CYCLES = 20_000_000,
  parameter int unsigned WORD_W        = 16,
  parameter int unsigned CNT_W         = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_inject,
  input  logic                 sw_reset,
  input  logic [WORD_W-1:0]    plain_dout,
  input  logic [WORD_W-1:0]    guard_dout,
  output logic                 tm_rst,
  output logic                 tm_start,
  output logic                 tm_rw,
  output logic [1:0]           tm_inject,
  output logic [WORD_W-1:0]    tm_word,
  output logic [2*CNT_W-1:0]   display_word,
  output logic [1:0]           plain_status,
  output logic [1:0]           guard_status
);

  localparam int unsigned PH_W = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PERIOD_CYCLES - 1);
  localparam logic [PH_W-1:0] PH_READ  = PH_W'(0);
  localparam logic [PH_W-1:0] PH_WRITE = PH_W'(3);
  localparam logic [PH_W-1:0] PH_CMP   = PH_W'(6);
  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_FAULT = 2'd1;
  localparam logic [1:0] ST_INRST = 2'd2;

  logic [PH_W-1:0]   phase;
  logic [WORD_W-1:0] word;
  logic              do_cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= '0;
    else if (phase == PH_LAST)  phase <= '0;
    else                        phase <= phase + 1'b1;
  end

  assign do_cmp = (phase == PH_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (sw_reset) word <= '0;
    else if (do_cmp)   word <= word + 1'b1;
  end

  assign tm_rst    = sw_reset;
  assign tm_start  = (phase == PH_READ) || (phase == PH_WRITE);
  assign tm_rw     = (phase == PH_WRITE);
  assign tm_inject = sw_inject ? 2'b11 : 2'b00;
  assign tm_word   = word;

  logic [1:0][WORD_W-1:0] dout;
  logic [1:0][CNT_W-1:0]  tally;
  logic [1:0][1:0]        status;

  assign dout = {guard_dout, plain_dout};

  for (genvar m = 0; m < 2; m++) begin : g_mach
    logic hit;
    assign hit = (dout[m] == word);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tally[m] <= '0;
      else if (sw_reset)
        tally[m] <= '0;
      else if (do_cmp && !hit && (tally[m] != {CNT_W{1'b1}}))
        tally[m] <= tally[m] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       status[m] <= ST_OK;
      else if (do_cmp)  status[m] <= hit ? ST_OK : (sw_reset ? ST_INRST : ST_FAULT);
    end
  end

  assign display_word = {tally[1], tally[0]};
  assign plain_status = status[0];
  assign guard_status = status[1];

endmodule

module fsm_fault_sequencer_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sw_inject,
  input logic               sw_reset,
  input logic               tm_rst,
  input logic               tm_start,
  input logic [1:0]         tm_inject,
  input logic [WORD_W-1:0]  tm_word,
  input logic [2*CNT_W-1:0] display_word,
  input logic [1:0]         plain_status,
  input logic [1:0]         guard_status
);

  assert_inject_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_inject == 2'b00) || (tm_inject == 2'b11));

  assert_inject_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_inject |-> (tm_inject == 2'b11));

  assert_reset_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |-> tm_rst);

  assert_reset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (display_word == '0) && (tm_word == '0));

  assert_single_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tm_start |=> !tm_start);

  assert_status_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_status != 2'b11) && (guard_status != 2'b11));

  assert_plain_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sw_reset) |->
      (display_word[CNT_W-1:0] == $past(display_word[CNT_W-1:0])) ||
      (display_word[CNT_W-1:0] == $past(display_word[CNT_W-1:0]) + 1'b1));

  assert_inrst_uncounted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_status == 2'b10) |-> (display_word[CNT_W-1:0] == '0));

  assert_plain_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sw_reset) && ($past(display_word[CNT_W-1:0]) == {CNT_W{1'b1}})) |->
      (display_word[CNT_W-1:0] == {CNT_W{1'b1}}));

  assert_guard_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sw_reset) && ($past(display_word[2*CNT_W-1:CNT_W]) == {CNT_W{1'b1}})) |->
      (display_word[2*CNT_W-1:CNT_W] == {CNT_W{1'b1}}));

endmodule

bind fsm_fault_sequencer fsm_fault_sequencer_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_fsm_fault_sequencer.sv
module sim_fsm_fault_sequencer;
  localparam int P = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_inject = 1'b0;
  logic sw_reset = 1'b0;
  logic [15:0] plain_dout, guard_dout;
  logic tm_rst, tm_start, tm_rw;
  logic [1:0] tm_inject, plain_status, guard_status;
  logic [15:0] tm_word, display_word;

  always #5 clk = ~clk;

  fsm_fault_sequencer #(.PERIOD_CYCLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_inject(sw_inject), .sw_reset(sw_reset),
    .plain_dout(plain_dout), .guard_dout(guard_dout),
    .tm_rst(tm_rst), .tm_start(tm_start), .tm_rw(tm_rw), .tm_inject(tm_inject),
    .tm_word(tm_word), .display_word(display_word),
    .plain_status(plain_status), .guard_status(guard_status));

  // Behavioural transfer machines: 0 idle, 1 read, 2 write
  logic [1:0]  p_st, g_st;
  logic [15:0] p_cap, p_out, g_cap, g_out;
  logic corrupt_p = 1'b0, corrupt_g = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n || tm_rst) begin
      p_st <= 2'd0; p_out <= '0;
    end else begin
      case (p_st)
        2'd0: if (tm_start) p_st <= (tm_rw ? 2'd2 : 2'd1) | tm_inject;
        2'd1: begin p_cap <= tm_word; p_st <= 2'd0 | tm_inject; end
        2'd2: begin p_out <= p_cap;   p_st <= 2'd0 | tm_inject; end
        default: p_st <= p_st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tm_rst) begin
      g_st <= 2'd0; g_out <= '0;
    end else begin
      case (g_st)
        2'd0: if (tm_start) g_st <= tm_rw ? 2'd2 : 2'd1;
        2'd1: begin g_cap <= tm_word; g_st <= 2'd0; end
        2'd2: begin g_out <= g_cap;   g_st <= 2'd0; end
        default: begin g_out <= g_cap; g_st <= 2'd0; end
      endcase
    end
  end

  assign plain_dout = p_out ^ (corrupt_p ? 16'h00FF : 16'h0000);
  assign guard_dout = g_out ^ (corrupt_g ? 16'h00FF : 16'h0000);

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic goto_phase(input int ph);
    step();
    while ((cyc % P) != ph) step();
  endtask

  task automatic t_reset_state();
    check(display_word == 16'h0 && tm_word == 16'h0, "R9 tallies/word", {display_word, tm_word}, 32'h0);
    check(plain_status == 2'd0 && guard_status == 2'd0, "R9 status", {plain_status, guard_status}, 0);
    check(tm_inject == 2'b00 && !tm_rst, "R1 idle inject", {tm_rst, tm_inject}, 0);
  endtask

  task automatic t_sequence();
    int errs = 0;
    for (int ph = 0; ph < P; ph++) begin
      if (ph > 0) step();
      if (tm_start !== (ph == 0 || ph == 3)) errs++;
      if (tm_start && (tm_rw !== (ph == 3))) errs++;
    end
    check(errs == 0, "R4 start/rw phases", errs, 0);
    step();
    check(tm_start && !tm_rw, "R4 next period read", {tm_start, tm_rw}, 2'b10);
  endtask

  task automatic t_clean();
    goto_phase(7);
    check(tm_word == 16'd2, "R3 word after compare", tm_word, 2);
    check(plain_status == 2'd0 && guard_status == 2'd0, "R5 ok status", {plain_status, guard_status}, 0);
    check(display_word == 16'h0, "R6 no count when ok", display_word, 0);
  endtask

  task automatic t_inject();
    goto_phase(8);
    sw_inject = 1'b1;
    #1 check(tm_inject == 2'b11, "R1 inject code", tm_inject, 2'b11);
    goto_phase(7);
    check(plain_status == 2'd1 && guard_status == 2'd0, "R5 faulted code", {plain_status, guard_status}, 4'b0100);
    check(display_word == 16'h0001, "R6 first fault", display_word, 16'h0001);
    goto_phase(7);
    check(display_word == 16'h0002, "R6 second fault", display_word, 16'h0002);
    goto_phase(8);
    sw_inject = 1'b0;
    #1 check(tm_inject == 2'b00, "R1 inject off", tm_inject, 0);
    goto_phase(7);
    check(display_word == 16'h0003, "R6 locked machine keeps failing", display_word, 16'h0003);
  endtask

  task automatic t_pack();
    goto_phase(8);
    corrupt_g = 1'b1;
    goto_phase(7);
    check(display_word == 16'h0104, "R8 packing", display_word, 16'h0104);
    check(guard_status == 2'd1, "R5 guard faulted", guard_status, 1);
    goto_phase(8);
    corrupt_g = 1'b0;
  endtask

  task automatic t_reset_switch();
    sw_reset = 1'b1;
    corrupt_p = 1'b1;
    #1 check(tm_rst == 1'b1, "R2 reset line", tm_rst, 1);
    step();
    check(display_word == 16'h0 && tm_word == 16'h0, "R2 cleared", {display_word, tm_word}, 0);
    goto_phase(7);
    check(plain_status == 2'd2, "R5 in-reset code", plain_status, 2);
    check(display_word == 16'h0, "R6 no count in reset", display_word, 0);
    check(tm_word == 16'h0, "R2 word held zero", tm_word, 0);
    goto_phase(8);
    sw_reset = 1'b0;
    corrupt_p = 1'b0;
    goto_phase(7);
    check(tm_word == 16'd1 && plain_status == 2'd0 && guard_status == 2'd0,
          "R3 recovered after reset", {tm_word, plain_status, guard_status}, {16'd1, 4'd0});
  endtask

  task automatic t_saturate();
    goto_phase(8);
    sw_inject = 1'b1;
    for (int i = 0; i < 255; i++) goto_phase(7);
    check(display_word == 16'h00FF, "R7 reaches max", display_word, 16'h00FF);
    for (int i = 0; i < 3; i++) goto_phase(7);
    check(display_word == 16'h00FF, "R7 saturated", display_word, 16'h00FF);
    check(guard_status == 2'd0, "R6 guard unaffected", guard_status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    t_reset_state();
    t_sequence();
    t_clean();
    t_inject();
    t_pack();
    t_reset_switch();
    t_saturate();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule